// File: doc/BRIEF.md
# USB Device Link State Monitor

This block follows the condition of a full-speed USB device link. It receives the decoded line condition (a single-ended-zero flag and an idle/J flag), the VBUS sense input with a software override, the software enable bit, and a valid start-of-frame strobe that carries an 11-bit frame number. From these inputs it keeps a 3-bit link state, the current frame number, a host-lost status bit and the 7-bit device address register. It raises one-cycle event pulses when the following happen:

- VBUS appears or goes away.
- A link reset is detected.
- The link suspends or resumes.
- The host is lost.
- A new frame is loaded.

A free-running prescaler divides the system clock into 1 µs ticks. Three threshold timers count those ticks: one for SE0 (link reset), one for constant idle (suspend) and one for the gap between start-of-frame strobes (host loss). Each timer starts again from zero whenever the condition it watches stops. Line decoding, packet parsing and the CRC check of the start-of-frame token are done outside the block.

Top module: `usb_link_monitor`

## Requirements
- R1: `link_state_o` takes only these encodings: 0 disconnected, 1 powered and not yet reset, 2 suspended before any reset, 3 active, 4 suspended after being active, 5 active with no start-of-frame since the last reset. After reset it reads 0, and `frame_o`, `host_lost_o` and every event output read 0.
- R2: With the link enabled and powered and the state not 0, SE0 held for `RESET_US` ticks raises `ev_reset_o` for one cycle, moves the state to 5 and zeroes `dev_addr_o`.
- R3: Idle (idle flag set, SE0 clear) held for `SUSPEND_US` ticks raises `ev_suspend_o`. The state moves from 1 to 2, or from 3 or 5 to 4.
- R4: In state 2 or 4, any non-idle line condition raises `ev_resume_o` on the next edge. State 2 returns to 1 and state 4 returns to 3.
- R5: In state 3, `HOSTLOST_US` ticks without a start-of-frame strobe set `host_lost_o` and raise `ev_host_lost_o`. The next start-of-frame strobe clears `host_lost_o`.
- R6: A start-of-frame strobe while enabled and powered loads `sof_frame_i` into `frame_o` and raises `ev_frame_o` on the next edge. It also moves state 5 to state 3.
- R7: When the effective VBUS sense is low, the state goes to 0 on the next edge. A falling edge of the effective sense raises `ev_disconnected_o`, and a rising edge raises `ev_connected_o`.
- R8: When `sense_ovr_en_i` is 1, `sense_ovr_val_i` takes the place of `vbus_sense_i` as the effective sense. `sense_raw_o` always follows `vbus_sense_i`.
- R9: While `enable_i` is 0, the state is held at 0 or 1. No reset, suspend, resume, host-lost or frame event is raised, and `frame_o` keeps its value.
- R10: Each threshold counts a continuous run of its condition. SE0 held for at most `(RESET_US-1)*TICK_DIV` cycles and then released raises no reset and leaves the state unchanged.
- R11: `addr_wr_i` loads `addr_wdata_i` into `dev_addr_o` on the next edge. A link reset on the same edge takes priority and zeroes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Software enable of the link |
| vbus_sense_i | input | 1 | Raw VBUS sense pin |
| sense_ovr_en_i | input | 1 | Use the override value instead of the pin |
| sense_ovr_val_i | input | 1 | Override value for VBUS sense |
| line_se0_i | input | 1 | Line is at single-ended zero |
| line_idle_i | input | 1 | Line is idle (J) |
| sof_valid_i | input | 1 | Valid start-of-frame strobe |
| sof_frame_i | input | FRAME_W | Frame number carried by the strobe |
| addr_wr_i | input | 1 | Write strobe for the device address |
| addr_wdata_i | input | ADDR_W | Device address write data |
| link_state_o | output | 3 | Link state encoding |
| frame_o | output | FRAME_W | Last loaded frame number |
| host_lost_o | output | 1 | Host-lost status |
| sense_raw_o | output | 1 | Raw sense pin value |
| dev_addr_o | output | ADDR_W | Device address register |
| ev_connected_o | output | 1 | Effective VBUS rose |
| ev_disconnected_o | output | 1 | Effective VBUS fell |
| ev_reset_o | output | 1 | Link reset detected |
| ev_suspend_o | output | 1 | Link suspended |
| ev_resume_o | output | 1 | Link resumed |
| ev_host_lost_o | output | 1 | Host lost |
| ev_frame_o | output | 1 | Frame number updated |

## Verification
The bench builds the block with `TICK_DIV=2`, `RESET_US=3`, `SUSPEND_US=12` and `HOSTLOST_US=20`, so every threshold is reached within a few dozen cycles. At these sizes every SE0 length up to the threshold boundary can be swept. Each latency is also checked against the exact window the bench computes from the tick period, the threshold and the unknown prescaler phase. Every state transition, both suspend targets and both resume targets are exercised within a short run.

// File: rtl/usb_lm_pkg.sv
package usb_lm_pkg;
   typedef enum logic [2:0] {
      LS_DISCONN   = 3'd0,
      LS_POWERED   = 3'd1,
      LS_PWR_SUSP  = 3'd2,
      LS_ACTIVE    = 3'd3,
      LS_SUSPEND   = 3'd4,
      LS_ACT_NOSOF = 3'd5
   } link_state_e;
endpackage

// File: rtl/usb_lm_tick.sv
module usb_lm_tick #(
   parameter int unsigned DIV = 48
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);
   localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 1) begin : g_bad_div
         $error("usb_lm_tick: DIV must be at least 1");
      end else if (DIV == 1) begin : g_every_cycle
         assign tick_o = 1'b1;
      end else begin : g_divider
         logic [W-1:0] cnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                 cnt_q <= '0;
            else if (cnt_q == W'(DIV-1)) cnt_q <= '0;
            else                         cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = (cnt_q == W'(DIV-1));
      end
   endgenerate
endmodule

// File: rtl/usb_lm_timer.sv
module usb_lm_timer #(
   parameter int unsigned LIMIT = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic run_i,
   output logic fire_o
);
   localparam int unsigned W = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("usb_lm_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           cnt_q <= '0;
      else if (!run_i)                       cnt_q <= '0;
      else if (tick_i && cnt_q != W'(LIMIT)) cnt_q <= cnt_q + 1'b1;
   end

   assign fire_o = run_i && tick_i && (cnt_q == W'(LIMIT-1));
endmodule

// File: rtl/usb_lm_fsm.sv
module usb_lm_fsm
   import usb_lm_pkg::*;
#(
   parameter int unsigned FRAME_W = 11,
   parameter int unsigned ADDR_W  = 7
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               enable_i,
   input  logic               sense_i,
   input  logic               se0_i,
   input  logic               idle_i,
   input  logic               sof_valid_i,
   input  logic [FRAME_W-1:0] sof_frame_i,
   input  logic               addr_wr_i,
   input  logic [ADDR_W-1:0]  addr_wdata_i,
   input  logic               rst_fire_i,
   input  logic               susp_fire_i,
   input  logic               lost_fire_i,
   output logic               rst_run_o,
   output logic               susp_run_o,
   output logic               lost_run_o,
   output link_state_e        state_o,
   output logic [FRAME_W-1:0] frame_o,
   output logic               host_lost_o,
   output logic [ADDR_W-1:0]  addr_o,
   output logic               ev_conn_o,
   output logic               ev_disc_o,
   output logic               ev_reset_o,
   output logic               ev_susp_o,
   output logic               ev_resume_o,
   output logic               ev_lost_o,
   output logic               ev_frame_o
);
   link_state_e        state_q, state_d;
   logic [FRAME_W-1:0] frame_d;
   logic [ADDR_W-1:0]  addr_d;
   logic               lost_d, sense_q;
   logic               live, idle_now, suspended;

   always_comb begin
      live       = sense_i & enable_i;
      idle_now   = idle_i & ~se0_i;
      suspended  = (state_q == LS_PWR_SUSP) || (state_q == LS_SUSPEND);
      rst_run_o  = live & se0_i & (state_q != LS_DISCONN);
      susp_run_o = live & idle_now &
                   (state_q inside {LS_POWERED, LS_ACTIVE, LS_ACT_NOSOF});
      lost_run_o = live & (state_q == LS_ACTIVE) & ~sof_valid_i;

      state_d = state_q;
      if (!sense_i)                                   state_d = LS_DISCONN;
      else if (!enable_i || state_q == LS_DISCONN)    state_d = LS_POWERED;
      else if (rst_fire_i)                            state_d = LS_ACT_NOSOF;
      else if (susp_fire_i)                           state_d = (state_q == LS_POWERED) ?
                                                                LS_PWR_SUSP : LS_SUSPEND;
      else if (state_q == LS_PWR_SUSP && !idle_now)   state_d = LS_POWERED;
      else if (state_q == LS_SUSPEND && !idle_now)    state_d = LS_ACTIVE;
      else if (sof_valid_i && state_q == LS_ACT_NOSOF) state_d = LS_ACTIVE;

      frame_d = (live && sof_valid_i) ? sof_frame_i : frame_o;

      if (rst_fire_i)     addr_d = '0;
      else if (addr_wr_i) addr_d = addr_wdata_i;
      else                addr_d = addr_o;

      if (!live || sof_valid_i || rst_fire_i) lost_d = 1'b0;
      else if (lost_fire_i)                   lost_d = 1'b1;
      else                                    lost_d = host_lost_o;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= LS_DISCONN;
         frame_o     <= '0;
         addr_o      <= '0;
         host_lost_o <= 1'b0;
         sense_q     <= 1'b0;
         ev_conn_o   <= 1'b0;
         ev_disc_o   <= 1'b0;
         ev_reset_o  <= 1'b0;
         ev_susp_o   <= 1'b0;
         ev_resume_o <= 1'b0;
         ev_lost_o   <= 1'b0;
         ev_frame_o  <= 1'b0;
      end else begin
         state_q     <= state_d;
         frame_o     <= frame_d;
         addr_o      <= addr_d;
         host_lost_o <= lost_d;
         sense_q     <= sense_i;
         ev_conn_o   <= sense_i & ~sense_q;
         ev_disc_o   <= ~sense_i & sense_q;
         ev_reset_o  <= rst_fire_i;
         ev_susp_o   <= susp_fire_i;
         ev_resume_o <= live & suspended & ~idle_now & ~rst_fire_i;
         ev_lost_o   <= lost_fire_i;
         ev_frame_o  <= live & sof_valid_i;
      end
   end

   assign state_o = state_q;
endmodule

// File: rtl/usb_link_monitor.sv
module usb_link_monitor
   import usb_lm_pkg::*;
#(
   parameter int unsigned TICK_DIV    = 48,
   parameter int unsigned RESET_US    = 3,
   parameter int unsigned SUSPEND_US  = 3000,
   parameter int unsigned HOSTLOST_US = 4096,
   parameter int unsigned FRAME_W     = 11,
   parameter int unsigned ADDR_W      = 7
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               enable_i,
   input  logic               vbus_sense_i,
   input  logic               sense_ovr_en_i,
   input  logic               sense_ovr_val_i,
   input  logic               line_se0_i,
   input  logic               line_idle_i,
   input  logic               sof_valid_i,
   input  logic [FRAME_W-1:0] sof_frame_i,
   input  logic               addr_wr_i,
   input  logic [ADDR_W-1:0]  addr_wdata_i,
   output logic [2:0]         link_state_o,
   output logic [FRAME_W-1:0] frame_o,
   output logic               host_lost_o,
   output logic               sense_raw_o,
   output logic [ADDR_W-1:0]  dev_addr_o,
   output logic               ev_connected_o,
   output logic               ev_disconnected_o,
   output logic               ev_reset_o,
   output logic               ev_suspend_o,
   output logic               ev_resume_o,
   output logic               ev_host_lost_o,
   output logic               ev_frame_o
);
   generate
      if (RESET_US >= SUSPEND_US || FRAME_W < 1 || ADDR_W < 1) begin : g_bad_cfg
         $error("usb_link_monitor: inconsistent parameters");
      end
   endgenerate

   logic        tick, sense_eff;
   logic        rst_run, susp_run, lost_run;
   logic        rst_fire, susp_fire, lost_fire;
   link_state_e state;

   assign sense_eff   = sense_ovr_en_i ? sense_ovr_val_i : vbus_sense_i;
   assign sense_raw_o = vbus_sense_i;

   usb_lm_tick #(.DIV(TICK_DIV)) tick_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

   usb_lm_timer #(.LIMIT(RESET_US)) rst_tmr_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .run_i(rst_run), .fire_o(rst_fire));
   usb_lm_timer #(.LIMIT(SUSPEND_US)) susp_tmr_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .run_i(susp_run), .fire_o(susp_fire));
   usb_lm_timer #(.LIMIT(HOSTLOST_US)) lost_tmr_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .run_i(lost_run), .fire_o(lost_fire));

   usb_lm_fsm #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) fsm_i (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .enable_i(enable_i), .sense_i(sense_eff),
      .se0_i(line_se0_i), .idle_i(line_idle_i),
      .sof_valid_i(sof_valid_i), .sof_frame_i(sof_frame_i),
      .addr_wr_i(addr_wr_i), .addr_wdata_i(addr_wdata_i),
      .rst_fire_i(rst_fire), .susp_fire_i(susp_fire), .lost_fire_i(lost_fire),
      .rst_run_o(rst_run), .susp_run_o(susp_run), .lost_run_o(lost_run),
      .state_o(state), .frame_o(frame_o), .host_lost_o(host_lost_o),
      .addr_o(dev_addr_o),
      .ev_conn_o(ev_connected_o), .ev_disc_o(ev_disconnected_o),
      .ev_reset_o(ev_reset_o), .ev_susp_o(ev_suspend_o),
      .ev_resume_o(ev_resume_o), .ev_lost_o(ev_host_lost_o),
      .ev_frame_o(ev_frame_o));

   assign link_state_o = state;
endmodule

// File: rtl/usb_link_monitor_chk.sv
module usb_link_monitor_chk #(
   parameter int unsigned FRAME_W = 11,
   parameter int unsigned ADDR_W  = 7
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               enable_i,
   input logic               vbus_sense_i,
   input logic               sense_ovr_en_i,
   input logic               sense_ovr_val_i,
   input logic [FRAME_W-1:0] sof_frame_i,
   input logic [2:0]         link_state_o,
   input logic [FRAME_W-1:0] frame_o,
   input logic               host_lost_o,
   input logic [ADDR_W-1:0]  dev_addr_o,
   input logic               ev_reset_o,
   input logic               ev_suspend_o,
   input logic               ev_resume_o,
   input logic               ev_host_lost_o,
   input logic               ev_frame_o
);
   logic eff;
   assign eff = sense_ovr_en_i ? sense_ovr_val_i : vbus_sense_i;

   assert_state_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_state_o <= 3'd5);

   assert_reset_effect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_reset_o |-> (link_state_o == 3'd5 && dev_addr_o == '0));

   assert_reset_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_reset_o |=> !ev_reset_o);

   assert_suspend_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_suspend_o |-> (link_state_o == 3'd2 || link_state_o == 3'd4));

   assert_resume_target_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_resume_o |-> (link_state_o == 3'd1 || link_state_o == 3'd3));

   assert_host_lost_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_host_lost_o |-> host_lost_o);

   assert_frame_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_frame_o |-> frame_o == $past(sof_frame_i));

   assert_vbus_loss_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !eff |=> link_state_o == 3'd0);

   assert_disabled_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> (link_state_o <= 3'd1 && !ev_reset_o && !ev_suspend_o &&
                     !ev_resume_o && !ev_host_lost_o && !ev_frame_o));
endmodule

bind usb_link_monitor usb_link_monitor_chk #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/usb_link_monitor_tb_top.sv
module usb_link_monitor_tb_top;
   localparam int DIV = 2, LRST = 3, LSUSP = 12, LLOST = 20;

   logic clk = 1'b0, rst_n = 1'b0;
   logic en = 0, vbus = 0, oen = 0, oval = 0, se0 = 0, idle = 0, sof = 0, awr = 0;
   logic [10:0] sfr = '0;
   logic [6:0]  awd = '0;
   logic [2:0]  st;
   logic [10:0] fr;
   logic        hl, raw;
   logic [6:0]  addr;
   logic        e_con, e_dis, e_rst, e_sus, e_res, e_lost, e_frm;

   int n_chk = 0, n_fail = 0, rst_seen = 0;
   bit done = 0;

   always #5 clk = ~clk;

   usb_link_monitor #(.TICK_DIV(DIV), .RESET_US(LRST), .SUSPEND_US(LSUSP),
                      .HOSTLOST_US(LLOST)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .vbus_sense_i(vbus),
      .sense_ovr_en_i(oen), .sense_ovr_val_i(oval), .line_se0_i(se0),
      .line_idle_i(idle), .sof_valid_i(sof), .sof_frame_i(sfr),
      .addr_wr_i(awr), .addr_wdata_i(awd), .link_state_o(st), .frame_o(fr),
      .host_lost_o(hl), .sense_raw_o(raw), .dev_addr_o(addr),
      .ev_connected_o(e_con), .ev_disconnected_o(e_dis), .ev_reset_o(e_rst),
      .ev_suspend_o(e_sus), .ev_resume_o(e_res), .ev_host_lost_o(e_lost),
      .ev_frame_o(e_frm));

   always @(negedge clk) if (e_rst) rst_seen++;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
   endtask

   // edges until the chosen event output is seen (0 = reset, 1 = suspend, 2 = host lost)
   task automatic measure(input int which, input int maxn, output int n);
      n = 0;
      for (int i = 1; i <= maxn; i++) begin
         @(posedge clk); #1;
         if ((which == 0 && e_rst) || (which == 1 && e_sus) || (which == 2 && e_lost)) begin
            n = i; break;
         end
      end
   endtask

   task automatic win(input string req, input int n, input int lim);
      chk(req, int'(n >= (lim-1)*DIV+1 && n <= lim*DIV), 1);
   endtask

   task automatic send_sof(input logic [10:0] f);
      sof = 1; sfr = f; step(1); sof = 0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      step(2);
      // R1: reset values
      chk("R1 state", st, 0); chk("R1 frame", fr, 0); chk("R1 hostlost", hl, 0);
      chk("R1 events", {e_con, e_dis, e_rst, e_sus, e_res, e_lost, e_frm}, 0);
      rst_n = 1; step(1);

      // R7 connect while disabled; R9 disabled link ignores SE0/idle/SOF
      vbus = 1; step(1);
      chk("R7 connected", e_con, 1); chk("R9 state powered", st, 1);
      se0 = 1; step(12); se0 = 0; idle = 1; step(30); idle = 0;
      sof = 1; sfr = 11'h0AA; step(1); sof = 0;
      chk("R9 no frame event", e_frm, 0); chk("R9 frame kept", fr, 0);
      chk("R9 no reset", rst_seen, 0); chk("R9 state held", st, 1);

      // R11 address write
      en = 1; awr = 1; awd = 7'h2A; step(1); awr = 0;
      chk("R11 addr", addr, 7'h2A);

      // R10 sweep of short SE0 runs
      for (int len = 1; len <= (LRST-1)*DIV; len++) begin
         se0 = 1; step(len); se0 = 0; step(2);
         chk("R10 no reset", rst_seen, 0); chk("R10 state", st, 1);
      end

      // R2 long SE0
      se0 = 1; measure(0, 40, n); win("R2 latency", n, LRST);
      chk("R2 state", st, 5); chk("R2 addr zero", addr, 0);
      step(4); chk("R2 single pulse", rst_seen, 1);
      se0 = 0; step(1);

      // R6 frame sweep
      foreach (sfr_list[i]) begin
         send_sof(sfr_list[i]);
         chk("R6 frame event", e_frm, 1); chk("R6 frame", fr, sfr_list[i]);
         chk("R6 active", st, 3);
      end

      // R5 host lost
      measure(2, 80, n); win("R5 latency", n, LLOST);
      chk("R5 status set", hl, 1);
      send_sof(11'h010); chk("R5 status cleared", hl, 0);

      // R3 suspend from active, R4 resume
      idle = 1; measure(1, 60, n); win("R3 latency active", n, LSUSP);
      chk("R3 state 4", st, 4);
      idle = 0; step(1);
      chk("R4 resume event", e_res, 1); chk("R4 back to 3", st, 3);

      // R7 VBUS loss and regain
      vbus = 0; step(1);
      chk("R7 disconnected ev", e_dis, 1); chk("R7 state 0", st, 0);
      vbus = 1; step(1);
      chk("R7 connected ev", e_con, 1); chk("R7 state 1", st, 1);

      // R3 powered suspend, R4 resume to powered
      idle = 1; measure(1, 60, n); win("R3 latency powered", n, LSUSP);
      chk("R3 state 2", st, 2);
      idle = 0; step(1);
      chk("R4 resume event pw", e_res, 1); chk("R4 back to 1", st, 1);

      // R8 override
      oen = 1; oval = 0; step(1);
      chk("R8 override low", st, 0); chk("R8 raw kept", raw, 1);
      oval = 1; step(1); chk("R8 override high", st, 1);
      oen = 0; step(1);

      // R9 enable drop while active
      se0 = 1; measure(0, 40, n); se0 = 0; step(1);
      send_sof(11'h3FF); chk("R9 pre active", st, 3);
      en = 0; step(1); chk("R9 forced powered", st, 1);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   logic [10:0] sfr_list [4] = '{11'h123, 11'h7FF, 11'h000, 11'h555};
endmodule